// File: doc/BRIEF.md
# Configurable Registered/Combinational Output Cell

This block is one output cell of a sum-of-products logic array. It receives the OR result of its product-term group (`sum_in`) and turns it into a value for a bidirectional pin and a feedback bit that returns into the array. A four-bit configuration word sets the output polarity and chooses a combinational or registered output. It also picks the feedback source: register Q, the raw sum, or the pin level. Of the twelve legal settings, four reproduce the classic structures: registered or combinational output, either polarity, with feedback chosen automatically.

The cell holds one D flip-flop. It is clocked from one of four sources, chosen by `clk_sel`: the dedicated pin clock or a product-term clock, each in true or complement form. The design runs in the system clock domain. A two-state tracker follows the chosen clock level, and a low-to-high transition of that level becomes the capture strobe. A synchronous preset term forces Q high on a capture strobe. An asynchronous clear term forces Q low at once and overrides the preset. The pin is driven only while the enable product term is true. Otherwise the pin reads its external level, so it can act as an input.

Each machine uses its own names. The clock tracker has the states `LVL_LOW` and `LVL_HIGH`. It moves to `LVL_HIGH` when the chosen level is 1 and to `LVL_LOW` when it is 0, and the LOW-to-HIGH move is the capture strobe. The register has the states `Q_CLEAR` and `Q_SET`. It moves `Q_CLEAR`→`Q_SET` on a strobe with preset or a 1 sum. It moves `Q_SET`→`Q_CLEAR` on a strobe with no preset and a 0 sum. A clear or a reset sends it to `Q_CLEAR` from either state.

Top module: `mc_io_cell`

## Requirements
- R1: Configuration word `cfg` is split as follows. `cfg[0]` sets polarity: 1 drives the true value and 0 drives the inverted value. `cfg[1]` selects the output: 1 is the register Q, 0 is the combinational sum. `cfg[3:2]` selects feedback: 00 pin level, 01 register Q, 10 raw sum, 11 automatic (Q when registered, pin level when combinational).
- R2: In a combinational configuration, `pin_out` equals `sum_in`, or its inverse when active low, in the same cycle.
- R3: `pin_oe` follows `oe_term`. The pin level used for feedback is `pin_out` while enabled and `pin_in` while disabled.
- R4: In a registered configuration, Q takes `sum_in` only on a 0→1 transition of the selected clock level. It holds on falling edges and when the level is steady. The output shows Q or its inverse after the system clock edge that sees the transition.
- R5: `clk_sel[0]` selects the source (0 pin clock `pin_clk`, 1 product-term clock `term_clk`). `clk_sel[1]`=1 inverts the selected source.
- R6: With `preset_term` high at a capture transition, Q becomes 1 whatever `sum_in` is. Preset has no effect without a transition.
- R7: `clear_term` high forces Q to 0 immediately, without waiting for any clock edge, and holds it there.
- R8: With `clear_term` and `preset_term` both high at a capture transition, Q is 0.
- R9: Reset (`rst_n` low) clears Q. A selected clock level that is already high when reset ends produces no capture until it has first been seen low.
- R10: Feedback `fb_out` follows the source chosen by R1 in both registered and combinational configurations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up clear) |
| cfg | input | 4 | Cell configuration word (R1) |
| clk_sel | input | 2 | Clock source and polarity select (R5) |
| pin_clk | input | 1 | Dedicated clock pin level |
| term_clk | input | 1 | Product-term clock level |
| sum_in | input | 1 | OR result of the cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| preset_term | input | 1 | Global synchronous preset term |
| clear_term | input | 1 | Global asynchronous clear term |
| pin_in | input | 1 | External level on the pin when not driven |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback bit into the array |

## Verification
The bound checker checks several properties on every cycle. It checks that clear holds Q at zero, and that a capture strobe loads the sum or the preset value. It checks that Q holds between strobes and that the combinational output follows the sum under polarity. It also checks that register feedback tracks Q. Only the bench's scenarios can show the following: the decoding of every configuration, clock-source selection and inversion at the ports, and that clear acts between edges. The same applies to the absence of a spurious capture after reset and to the pin-level feedback under a disabled driver.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int CFG_W = 4;
    localparam int CSEL_W = 2;

    typedef enum logic [1:0] {
        FB_PIN  = 2'b00,
        FB_REG  = 2'b01,
        FB_SUM  = 2'b10,
        FB_AUTO = 2'b11
    } fb_sel_e;

    typedef struct packed {
        fb_sel_e fb;
        logic    registered;
        logic    active_high;
    } cell_cfg_t;

    typedef enum logic {
        Q_CLEAR = 1'b0,
        Q_SET   = 1'b1
    } q_state_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/mc_cfg_decode.sv
module mc_cfg_decode
    import mc_pkg::*;
(
    input  logic [CFG_W-1:0] cfg_bits,
    output cell_cfg_t        cfg_o
);
    cell_cfg_t raw;

    always_comb begin
        raw   = cell_cfg_t'(cfg_bits);
        cfg_o = raw;
        unique case (raw.fb)
            FB_PIN:  cfg_o.fb = FB_PIN;
            FB_REG:  cfg_o.fb = FB_REG;
            FB_SUM:  cfg_o.fb = FB_SUM;
            FB_AUTO: cfg_o.fb = raw.registered ? FB_REG : FB_PIN;
            default: cfg_o.fb = FB_PIN;
        endcase
    end
endmodule

// File: rtl/mc_clk_select.sv
module mc_clk_select
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSEL_W-1:0] clk_sel,
    input  logic              pin_clk,
    input  logic              term_clk,
    output logic              cap_edge
);
    logic       src_level;
    logic       level;
    lvl_state_e st, st_nxt;

    always_comb begin
        src_level = clk_sel[0] ? term_clk : pin_clk;
        level     = src_level ^ clk_sel[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LVL_HIGH;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt   = st;
        cap_edge = 1'b0;
        unique case (st)
            LVL_LOW: begin
                if (level) begin
                    st_nxt   = LVL_HIGH;
                    cap_edge = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!level) st_nxt = LVL_LOW;
            end
            default: st_nxt = LVL_HIGH;
        endcase
    end
endmodule

// File: rtl/mc_dff.sv
module mc_dff
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_term,
    input  logic preset_term,
    input  logic cap_edge,
    input  logic d,
    output logic q
);
    q_state_e st, st_nxt;

    always_ff @(posedge clk or negedge rst_n or posedge clear_term) begin
        if (!rst_n)          st <= Q_CLEAR;
        else if (clear_term) st <= Q_CLEAR;
        else                 st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            Q_CLEAR: if (cap_edge && (preset_term || d))   st_nxt = Q_SET;
            Q_SET:   if (cap_edge && !preset_term && !d)   st_nxt = Q_CLEAR;
            default: st_nxt = Q_CLEAR;
        endcase
    end

    always_comb q = (st == Q_SET);
endmodule

// File: rtl/mc_pin_mux.sv
module mc_pin_mux
    import mc_pkg::*;
(
    input  cell_cfg_t cfg_i,
    input  logic      sum_in,
    input  logic      q,
    input  logic      oe_term,
    input  logic      pin_in,
    output logic      pin_out,
    output logic      pin_oe,
    output logic      fb_out
);
    logic core;
    logic pin_level;

    always_comb begin
        core      = cfg_i.registered ? q : sum_in;
        pin_out   = cfg_i.active_high ? core : ~core;
        pin_oe    = oe_term;
        pin_level = oe_term ? pin_out : pin_in;
        unique case (cfg_i.fb)
            FB_PIN:  fb_out = pin_level;
            FB_REG:  fb_out = q;
            FB_SUM:  fb_out = sum_in;
            default: fb_out = pin_level;
        endcase
    end
endmodule

// File: rtl/mc_io_cell.sv
module mc_io_cell
    import mc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [CSEL_W-1:0] clk_sel,
    input  logic              pin_clk,
    input  logic              term_clk,
    input  logic              sum_in,
    input  logic              oe_term,
    input  logic              preset_term,
    input  logic              clear_term,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_out
);
    cell_cfg_t cfg_dec;
    logic      cap_edge;
    logic      q_bit;

    mc_cfg_decode u_dec (
        .cfg_bits (cfg),
        .cfg_o    (cfg_dec)
    );

    mc_clk_select u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (clk_sel),
        .pin_clk  (pin_clk),
        .term_clk (term_clk),
        .cap_edge (cap_edge)
    );

    mc_dff u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_term  (clear_term),
        .preset_term (preset_term),
        .cap_edge    (cap_edge),
        .d           (sum_in),
        .q           (q_bit)
    );

    mc_pin_mux u_mux (
        .cfg_i   (cfg_dec),
        .sum_in  (sum_in),
        .q       (q_bit),
        .oe_term (oe_term),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .fb_out  (fb_out)
    );
endmodule

// File: rtl/mc_io_cell_chk.sv
module mc_io_cell_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cfg,
    input logic       sum_in,
    input logic       preset_term,
    input logic       clear_term,
    input logic       pin_out,
    input logic       fb_out,
    input logic       cap_edge,
    input logic       q_bit
);
    AST_CLEAR_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        clear_term |-> !q_bit);                                              // R7
    AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_edge && preset_term && !clear_term) |=> (clear_term || q_bit)); // R6
    AST_CAPTURE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_edge && !preset_term && !clear_term)
            |=> (clear_term || (q_bit == $past(sum_in))));                   // R4
    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_edge && !clear_term) |=> (clear_term || $stable(q_bit)));      // R4
    AST_COMB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[1] |-> (pin_out == (cfg[0] ? sum_in : !sum_in)));               // R2
    AST_FB_REGISTER: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[3:2] == 2'b01) |-> (fb_out == q_bit));                          // R10
endmodule

bind mc_io_cell mc_io_cell_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .sum_in      (sum_in),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .pin_out     (pin_out),
    .fb_out      (fb_out),
    .cap_edge    (cap_edge),
    .q_bit       (q_bit)
);

// File: tb/mc_io_cell_test.sv
`timescale 1ns/1ps
module mc_io_cell_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg = 4'b0111;
    logic [1:0] clk_sel = 2'b10;
    logic pin_clk = 0, term_clk = 0, sum_in = 1, oe_term = 1;
    logic preset_term = 0, clear_term = 0, pin_in = 0;
    logic pin_out, pin_oe, fb_out;
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    mc_io_cell uut (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .clk_sel(clk_sel),
        .pin_clk(pin_clk), .term_clk(term_clk), .sum_in(sum_in),
        .oe_term(oe_term), .preset_term(preset_term), .clear_term(clear_term),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    // {cfg, sum, oe, pin_in, exp_out, exp_oe, exp_fb}; Q is 0 throughout
    localparam logic [9:0] VEC [11] = '{
        {4'b0001, 3'b110, 3'b111},  // R2 R3 pin fb, driven
        {4'b0001, 3'b100, 3'b100},  // R3 disabled, pin reads external
        {4'b0000, 3'b110, 3'b010},  // R2 active low
        {4'b0000, 3'b001, 3'b101},  // R3 low, external 1
        {4'b1001, 3'b100, 3'b101},  // R10 sum feedback
        {4'b1000, 3'b011, 3'b110},  // R10 sum fb, low polarity
        {4'b0101, 3'b110, 3'b110},  // R10 register fb on comb output
        {4'b1101, 3'b001, 3'b001},  // R1 automatic -> pin
        {4'b1100, 3'b110, 3'b010},  // R1 automatic, low polarity
        {4'b0011, 3'b111, 3'b010},  // R1 registered high, pin fb
        {4'b0010, 3'b000, 3'b100}   // R1 registered low, disabled
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset out", pin_out, 1'b0);
        rst_n = 1'b1;
        tick(); tick();
        chk("R9 no false capture", pin_out, 1'b0);
        chk("R9 no false capture fb", fb_out, 1'b0);

        clk_sel = 2'b00;
        tick();
        foreach (VEC[i]) begin
            {cfg, sum_in, oe_term, pin_in} = VEC[i][9:3];
            #1;
            chk($sformatf("R2/R3 vec%0d out", i), pin_out, VEC[i][2]);
            chk($sformatf("R3 vec%0d oe", i), pin_oe, VEC[i][1]);
            chk($sformatf("R10 vec%0d fb", i), fb_out, VEC[i][0]);
            @(negedge clk);
        end

        cfg = 4'b0111; oe_term = 1; sum_in = 1; pin_clk = 0;
        tick();
        pin_clk = 1; tick();
        chk("R4 capture rising", pin_out, 1'b1);
        chk("R10 reg fb", fb_out, 1'b1);
        sum_in = 0; tick();
        chk("R4 hold high level", pin_out, 1'b1);
        pin_clk = 0; tick();
        chk("R4 no capture falling", pin_out, 1'b1);
        pin_clk = 1; tick();
        chk("R4 capture zero", pin_out, 1'b0);

        clk_sel = 2'b10; sum_in = 1; tick();
        pin_clk = 0; tick();
        chk("R5 inverted pin clock", pin_out, 1'b1);

        clk_sel = 2'b01; term_clk = 0; sum_in = 0; tick();
        chk("R5 switch no edge", pin_out, 1'b1);
        term_clk = 1; tick();
        chk("R5 term clock capture", pin_out, 1'b0);

        preset_term = 1; term_clk = 0; tick();
        chk("R6 preset waits edge", pin_out, 1'b0);
        term_clk = 1; tick();
        chk("R6 preset sets", pin_out, 1'b1);
        preset_term = 0;

        clear_term = 1; #1;
        chk("R7 clear immediate", pin_out, 1'b0);
        @(negedge clk);
        clear_term = 0; tick();
        chk("R7 stays cleared", pin_out, 1'b0);

        preset_term = 1; clear_term = 1; term_clk = 0; tick();
        term_clk = 1; tick();
        chk("R8 clear beats preset", pin_out, 1'b0);
        preset_term = 0; clear_term = 0; tick();

        cfg = 4'b0110; #1;
        chk("R1 registered active low", pin_out, 1'b1);
        chk("R10 reg fb low pol", fb_out, 1'b0);
        cfg = 4'b1011; sum_in = 1; #1;
        chk("R10 sum fb registered", fb_out, 1'b1);
        cfg = 4'b1111; #1;
        chk("R1 automatic -> Q", fb_out, 1'b0);
        oe_term = 0; #1;
        chk("R3 enable off", pin_oe, 1'b0);
        @(negedge clk);

        oe_term = 1; cfg = 4'b0111; term_clk = 0; tick();
        term_clk = 1; tick();
        chk("R4 set before reset", pin_out, 1'b1);
        rst_n = 0; #1;
        chk("R9 reset clears", pin_out, 1'b0);
        @(negedge clk); rst_n = 1; tick(); tick();
        chk("R9 no capture on held level", pin_out, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule